// File: doc/BRIEF.md
# Tuning PLL Divider, Phase Comparator and Lock Core

This block is the synchronous digital heart of a frequency synthesizer for a tuner. It takes two tick streams on one system clock: one pulse per edge of the prescaled oscillator and one pulse per edge of the crystal. Each tick must last one clock, and the user synchronizes the source edges to the system clock. A 15-bit main divider scales down the oscillator ticks. A reference divider, whose ratio is chosen from three values by a two-bit select, scales down the crystal ticks.

The terminal counts of both dividers feed a two-flop phase/frequency comparator. Its up/down requests go to the charge pump. A lock detector watches the width of those requests. It raises a lock flag, and in one of the two normal test codes that flag also drops the pump current to its low setting.

Other test codes override the pump: off, constant sink or constant source. Two more codes route either the divided reference or half of the divided oscillator to the test/lock pin. In the remaining codes that pin carries the inverted lock flag. Every output is registered.

Top module: `synth_pll_core`

## Requirements
- R1: The main divider emits one terminal count every N oscillator ticks, with N taken as the unsigned binary value of `n_i`. With test code 101, `test_pin_o` toggles once per terminal count, so the spacing between toggles is N ticks.
- R2: The reference ratio is 640 when `rsb_i`=0 (whatever `rsa_i` is), 1024 when `rsb_i`=1 and `rsa_i`=0, and 512 when both are 1. With test code 100, `test_pin_o` pulses high for one clock per reference terminal count.
- R3: A change of N or of the reference ratio takes effect only at the next terminal count of that divider. The period in progress completes with the old ratio.
- R4: The comparator sets up on a reference terminal count and down on a main terminal count. When both are set, both clear on the next clock. In the normal codes 000 and 001, `up_o`/`dn_o` show these states one clock later.
- R5: The loop counts as locked once 4 consecutive comparisons each show an up-only or down-only request of at most LOCK_WIN clocks. Lock drops on the first comparison that exceeds LOCK_WIN.
- R6: Test codes 010 and 011 hold both `up_o` and `dn_o` low. Code 110 holds `dn_o` high and `up_o` low. Code 111 holds `up_o` high and `dn_o` low.
- R7: Outside codes 100 and 101, `test_pin_o` is the inverse of the lock flag, so it is low when locked.
- R8: The automatic current switch is active only in the normal code chosen by AUTO_ON_T0 (default: code 000). When it is active and the loop is locked, `reduced_n_o`=0 and `cur_hi_o`=0. Otherwise `reduced_n_o`=1 and `cur_hi_o` equals `cp_i` (1 selects high current).
- R9: `tune_en_o` is the inverse of `os_i`, so `os_i`=1 puts the tuning output in high impedance.
- R10: While reset is high, all outputs are 0 except `reduced_n_o` and `test_pin_o`, which are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick_i | input | 1 | One-clock pulse per crystal edge |
| vco_tick_i | input | 1 | One-clock pulse per prescaled oscillator edge |
| n_i | input | 15 | Main divide ratio |
| cp_i | input | 1 | Pump current request, 1 = high |
| t_i | input | 3 | Test code |
| rsa_i | input | 1 | Reference ratio select, low bit |
| rsb_i | input | 1 | Reference ratio select, high bit |
| os_i | input | 1 | Tuning output disable |
| up_o | output | 1 | Pump source request |
| dn_o | output | 1 | Pump sink request |
| cur_hi_o | output | 1 | Pump current select, 1 = high |
| tune_en_o | output | 1 | Tuning output enable |
| lock_o | output | 1 | Lock flag, 1 = locked |
| reduced_n_o | output | 1 | 0 when current is forced low by the auto switch |
| test_pin_o | output | 1 | Inverted lock, or a routed internal clock |

## Verification
The first stimulus is matched tick rates: crystal ticks every clock with ratio 512, and oscillator ticks every second clock with N=256. This pattern separates a comparator that settles and locks from one whose request widths grow. The second stimulus is mismatched rates, oscillator ticks every clock with N=300 and later 400. It forces wide requests and loss of lock, and the toggle spacing on the test pin shows whether a new N waits for the terminal count. Sweeping the three reference selections with the reference routed to the pin, and stepping through every test code and current/enable combination, shows the ratio decode, the pump overrides and the auto-switch choice apart.

// File: rtl/synth_pll_pkg.sv
package synth_pll_pkg;
  typedef enum logic [2:0] {
    TM_NORM_A  = 3'b000,
    TM_NORM_B  = 3'b001,
    TM_OFF_A   = 3'b010,
    TM_OFF_B   = 3'b011,
    TM_REF_OUT = 3'b100,
    TM_DIV_OUT = 3'b101,
    TM_SINK    = 3'b110,
    TM_SOURCE  = 3'b111
  } tmode_e;
endpackage

// File: rtl/synth_ratio_div.sv
module synth_ratio_div #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;
  logic         tc_q;
  logic         wrap;

  assign wrap = (cnt_q == act_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= ratio_i;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (tick_i) begin
        if (wrap) begin
          cnt_q <= '0;
          act_q <= ratio_i;
          tc_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tc_o = tc_q;

  AST_DIV_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (cnt_q == '0)); // R1
  AST_DIV_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q) && $stable(act_q)); // R3
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  input  logic div_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_i;
      dn_q <= dn_q | div_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_PFD_BOTH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q) |=> (!up_q && !dn_q)); // R4
  AST_PFD_REF_SETS: assert property (@(posedge clk) disable iff (rst)
    (ref_i && !(up_q && dn_q)) |=> up_q); // R4
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
  parameter int LOCK_WIN    = 2,
  parameter int LOCK_CYCLES = 4,
  parameter int ERR_W       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic dn_i,
  output logic lock_o
);
  localparam int GW = $clog2(LOCK_CYCLES + 1);

  logic [ERR_W-1:0] err_q;
  logic [GW-1:0]    good_q;
  logic             lock_q;
  logic             eval;
  logic             in_win;

  assign eval   = up_i && dn_i;
  assign in_win = (err_q <= ERR_W'(LOCK_WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (eval) begin
      err_q <= '0;
      if (in_win) begin
        if (good_q >= GW'(LOCK_CYCLES - 1)) lock_q <= 1'b1;
        if (good_q != GW'(LOCK_CYCLES)) good_q <= good_q + 1'b1;
      end else begin
        good_q <= '0;
        lock_q <= 1'b0;
      end
    end else if (up_i ^ dn_i) begin
      if (err_q != '1) err_q <= err_q + 1'b1;
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_DROP_WIDE: assert property (@(posedge clk) disable iff (rst)
    (eval && !in_win) |=> !lock_q); // R5
  AST_LOCK_NEEDS_EVAL: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(lock_q)); // R5
endmodule

// File: rtl/synth_pll_core.sv
module synth_pll_core
  import synth_pll_pkg::*;
#(
  parameter int NW          = 15,
  parameter int REF_A       = 640,
  parameter int REF_B       = 1024,
  parameter int REF_C       = 512,
  parameter int LOCK_WIN    = 2,
  parameter int LOCK_CYCLES = 4,
  parameter int ERR_W       = 8,
  parameter bit AUTO_ON_T0  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xtal_tick_i,
  input  logic          vco_tick_i,
  input  logic [NW-1:0] n_i,
  input  logic          cp_i,
  input  logic [2:0]    t_i,
  input  logic          rsa_i,
  input  logic          rsb_i,
  input  logic          os_i,
  output logic          up_o,
  output logic          dn_o,
  output logic          cur_hi_o,
  output logic          tune_en_o,
  output logic          lock_o,
  output logic          reduced_n_o,
  output logic          test_pin_o
);
  localparam int REF_MAX = (REF_A > REF_B) ? ((REF_A > REF_C) ? REF_A : REF_C)
                                           : ((REF_B > REF_C) ? REF_B : REF_C);
  localparam int RW = $clog2(REF_MAX + 1);

  logic [RW-1:0] ref_ratio;
  logic          ref_tc, div_tc;
  logic          pfd_up, pfd_dn;
  logic          locked;
  logic          div_half_q;
  logic          auto_en;
  logic          reduced_n;
  tmode_e        mode;

  assign mode = tmode_e'(t_i);

  always_comb begin
    if (!rsb_i)     ref_ratio = RW'(REF_A);
    else if (rsa_i) ref_ratio = RW'(REF_C);
    else            ref_ratio = RW'(REF_B);
  end

  synth_ratio_div #(.W(RW)) u_ref_div (
    .clk(clk), .rst(rst), .tick_i(xtal_tick_i), .ratio_i(ref_ratio), .tc_o(ref_tc)
  );

  synth_ratio_div #(.W(NW)) u_main_div (
    .clk(clk), .rst(rst), .tick_i(vco_tick_i), .ratio_i(n_i), .tc_o(div_tc)
  );

  synth_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_i(ref_tc), .div_i(div_tc), .up_o(pfd_up), .dn_o(pfd_dn)
  );

  synth_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_CYCLES(LOCK_CYCLES), .ERR_W(ERR_W)) u_lock (
    .clk(clk), .rst(rst), .up_i(pfd_up), .dn_i(pfd_dn), .lock_o(locked)
  );

  generate
    if (AUTO_ON_T0) begin : g_auto_b
      assign auto_en = (mode == TM_NORM_B);
    end else begin : g_auto_a
      assign auto_en = (mode == TM_NORM_A);
    end
  endgenerate

  assign reduced_n = !(auto_en && locked);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_half_q  <= 1'b0;
      up_o        <= 1'b0;
      dn_o        <= 1'b0;
      cur_hi_o    <= 1'b0;
      tune_en_o   <= 1'b0;
      lock_o      <= 1'b0;
      reduced_n_o <= 1'b1;
      test_pin_o  <= 1'b1;
    end else begin
      div_half_q  <= div_half_q ^ div_tc;
      lock_o      <= locked;
      tune_en_o   <= !os_i;
      reduced_n_o <= reduced_n;
      cur_hi_o    <= reduced_n & cp_i;
      case (mode)
        TM_OFF_A, TM_OFF_B: begin up_o <= 1'b0; dn_o <= 1'b0; end
        TM_SINK:            begin up_o <= 1'b0; dn_o <= 1'b1; end
        TM_SOURCE:          begin up_o <= 1'b1; dn_o <= 1'b0; end
        default:            begin up_o <= pfd_up; dn_o <= pfd_dn; end
      endcase
      case (mode)
        TM_REF_OUT: test_pin_o <= ref_tc;
        TM_DIV_OUT: test_pin_o <= div_half_q;
        default:    test_pin_o <= !locked;
      endcase
    end
  end

  AST_PUMP_OFF: assert property (@(posedge clk) disable iff (rst)
    (t_i[2:1] == 2'b01) |=> (!up_o && !dn_o)); // R6
  AST_PUMP_SINK: assert property (@(posedge clk) disable iff (rst)
    (t_i == 3'b110) |=> (dn_o && !up_o)); // R6
  AST_LOCK_PIN_INV: assert property (@(posedge clk) disable iff (rst)
    (t_i != 3'b100 && t_i != 3'b101) |=> (test_pin_o == !lock_o)); // R7
  AST_REDUCED_LOW_CUR: assert property (@(posedge clk) disable iff (rst)
    !reduced_n_o |-> !cur_hi_o); // R8
  AST_TUNE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tune_en_o == !$past(os_i))); // R9
endmodule

// File: tb/synth_pll_core_test.sv
module synth_pll_core_test;
  localparam int CLK_P = 10;
  localparam int WIN = 2;
  localparam int LC = 4;

  logic clk = 0, rst = 1;
  logic xtal_tick_i = 0, vco_tick_i = 0;
  logic [14:0] n_i = 15'd256;
  logic cp_i = 1, rsa_i = 1, rsb_i = 1, os_i = 1;
  logic [2:0] t_i = 3'b001;
  logic up_o, dn_o, cur_hi_o, tune_en_o, lock_o, reduced_n_o, test_pin_o;

  int total = 0, bad = 0;
  int xt_every = 1, vco_every = 2;
  bit done = 0;

  synth_pll_core uut (
    .clk(clk), .rst(rst), .xtal_tick_i(xtal_tick_i), .vco_tick_i(vco_tick_i),
    .n_i(n_i), .cp_i(cp_i), .t_i(t_i), .rsa_i(rsa_i), .rsb_i(rsb_i), .os_i(os_i),
    .up_o(up_o), .dn_o(dn_o), .cur_hi_o(cur_hi_o), .tune_en_o(tune_en_o),
    .lock_o(lock_o), .reduced_n_o(reduced_n_o), .test_pin_o(test_pin_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // tick generators
  initial begin
    int xc = 0, vc = 0;
    forever begin
      @(negedge clk);
      xtal_tick_i = (xc % xt_every) == 0;
      vco_tick_i  = (vc % vco_every) == 0;
      xc++; vc++;
    end
  end

  // behavioural reference model, compared each clock
  int rc, ract, rtc, dc, dact, dtc, dhalf, mup, mdn, err, good, lk;
  int o_up, o_dn, o_cur, o_tune, o_lock, o_red, o_pin;

  function automatic int ref_ratio(input logic a, input logic b);
    if (!b) return 640;
    return a ? 512 : 1024;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rc = 0; ract = ref_ratio(rsa_i, rsb_i); rtc = 0;
      dc = 0; dact = int'(n_i); dtc = 0; dhalf = 0;
      mup = 0; mdn = 0; err = 0; good = 0; lk = 0;
      o_up = 0; o_dn = 0; o_cur = 0; o_tune = 0; o_lock = 0; o_red = 1; o_pin = 1;
    end else begin
      int t, au, nt;
      t = int'(t_i);
      au = (t == 0);
      o_red = !(au && lk);
      o_cur = o_red ? int'(cp_i) : 0;
      o_tune = !os_i;
      o_lock = lk;
      if (t == 2 || t == 3) begin o_up = 0; o_dn = 0; end
      else if (t == 6) begin o_up = 0; o_dn = 1; end
      else if (t == 7) begin o_up = 1; o_dn = 0; end
      else begin o_up = mup; o_dn = mdn; end
      o_pin = (t == 4) ? rtc : (t == 5) ? dhalf : !lk;
      dhalf = dhalf ^ dtc;
      if (mup && mdn) begin
        if (err <= WIN) begin
          if (good >= LC - 1) lk = 1;
          if (good < LC) good++;
        end else begin
          good = 0; lk = 0;
        end
        err = 0;
      end else if (mup != mdn) begin
        if (err < 255) err++;
      end
      if (mup && mdn) begin mup = 0; mdn = 0; end
      else begin mup = mup | rtc; mdn = mdn | dtc; end
      nt = 0;
      if (xtal_tick_i) begin
        if (rc == ract - 1) begin rc = 0; ract = ref_ratio(rsa_i, rsb_i); nt = 1; end
        else rc++;
      end
      rtc = nt;
      nt = 0;
      if (vco_tick_i) begin
        if (dc == dact - 1) begin dc = 0; dact = int'(n_i); nt = 1; end
        else dc++;
      end
      dtc = nt;
    end
    #1;
    check(int'(up_o), o_up, "R4 R6 up_o");
    check(int'(dn_o), o_dn, "R4 R6 dn_o");
    check(int'(cur_hi_o), o_cur, "R8 cur_hi_o");
    check(int'(reduced_n_o), o_red, "R8 reduced_n_o");
    check(int'(tune_en_o), o_tune, "R9 tune_en_o");
    check(int'(lock_o), o_lock, "R5 lock_o");
    check(int'(test_pin_o), o_pin, "R1 R2 R3 R7 test_pin_o");
  end

  task automatic cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic toggle_gap(output int g);
    logic v;
    v = test_pin_o; g = 0;
    do begin @(negedge clk); g++; end while (test_pin_o === v && g < 5000);
  endtask

  task automatic pulse_gap(output int g);
    int w = 0;
    while (test_pin_o !== 1'b1 && w < 5000) begin @(negedge clk); w++; end
    @(negedge clk); g = 1;
    while (test_pin_o !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
  endtask

  initial begin
    int g;
    logic v;
    cycles(4);
    // R10 reset values
    check(int'(up_o) + int'(dn_o) + int'(cur_hi_o) + int'(tune_en_o) + int'(lock_o), 0, "R10 zero outs");
    check(int'(reduced_n_o), 1, "R10 reduced_n_o");
    check(int'(test_pin_o), 1, "R10 test_pin_o");
    rst = 0;
    cycles(4000);
    // matched rates: 512 crystal clocks vs 256 oscillator ticks every 2nd clock
    check(int'(lock_o), 1, "R5 lock after matched rates");
    check(int'(test_pin_o), 0, "R7 pin low when locked");
    check(int'(reduced_n_o), 1, "R8 code 001 no auto");
    check(int'(cur_hi_o), 1, "R8 cp high");
    t_i = 3'b000; cycles(3);
    check(int'(reduced_n_o), 0, "R8 auto reduce");
    check(int'(cur_hi_o), 0, "R8 forced low");
    t_i = 3'b001; cp_i = 0; cycles(3);
    check(int'(cur_hi_o), 0, "R8 cp low");
    cp_i = 1; os_i = 0; cycles(3);
    check(int'(tune_en_o), 1, "R9 enabled");
    os_i = 1; cycles(3);
    check(int'(tune_en_o), 0, "R9 disabled");
    t_i = 3'b010; cycles(600);
    check(int'(up_o) + int'(dn_o), 0, "R6 code 010 off");
    t_i = 3'b011; cycles(3);
    check(int'(up_o) + int'(dn_o), 0, "R6 code 011 off");
    t_i = 3'b110; cycles(3);
    check(int'(dn_o) * 2 + int'(up_o), 2, "R6 sink");
    t_i = 3'b111; cycles(3);
    check(int'(up_o) * 2 + int'(dn_o), 2, "R6 source");
    check(int'(test_pin_o), 0, "R7 pin in 111");
    // R1 / R3: oscillator every clock, N=300, then change mid period
    t_i = 3'b101; vco_every = 1; n_i = 15'd300;
    toggle_gap(g); toggle_gap(g); toggle_gap(g);
    check(g, 300, "R1 toggle spacing N=300");
    v = test_pin_o; g = 0;
    do begin
      @(negedge clk); g++;
      if (g == 100) n_i = 15'd400;
    end while (test_pin_o === v && g < 5000);
    check(g, 300, "R3 old N finishes period");
    toggle_gap(g);
    check(g, 400, "R1 R3 new N=400");
    cycles(3000);
    check(int'(lock_o), 0, "R5 lock lost on mismatch");
    // R2 reference ratios
    t_i = 3'b100; rsb_i = 0; rsa_i = 1;
    pulse_gap(g); pulse_gap(g);
    check(g, 640, "R2 ratio 640");
    rsb_i = 1; rsa_i = 0;
    pulse_gap(g); pulse_gap(g);
    check(g, 1024, "R2 ratio 1024");
    rsa_i = 1;
    pulse_gap(g); pulse_gap(g);
    check(g, 512, "R2 ratio 512");
    t_i = 3'b001; cycles(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule